// File: doc/BRIEF.md
# I/O MMU Control and Fault-Interrupt Register Block

This block is the register front end of an I/O memory management unit. A simple 32-bit register bus reaches a 256-byte window in which it finds a constant revision word, idle and auto-idle configuration, a self-timed soft reset with its own completion flag, enables for translation, hardware table walk and the emulation TLB, and the base address of the first-level translation table. The translation datapath, the table walker and the TLB live elsewhere. The block drives their configuration as plain output wires.

The same datapath reports its fault events here on five strobe inputs, each with the faulting device address. Each strobe sets a sticky status bit. Software clears a bit by writing one to it. A mask register selects which status bits raise the single interrupt line. The device address of the first fault is held until software acknowledges that fault.

Bus accesses are word-aligned. Only `bus_addr[7:2]` is decoded. Read data is combinational in the cycle the read is presented. Writes take effect at the clock edge of their cycle.

Top module: `iommu_regfile`

## Requirements
- R1: A read at byte offset 0x00 returns 0x00000011 (major 1 in bits 7:4, minor 1 in bits 3:0). A read at any offset not listed in these requirements returns 0. `bus_rdata` is 0 whenever no read is presented (`bus_sel`=0 or `bus_wr`=1).
- R2: Configuration word at 0x10: bits 4:3 hold the idle mode (0 force, 1 none, 2 smart) and bit 0 holds auto-idle. A write with bit 1 clear stores both fields. Both fields read back and drive `idle_mode` and `auto_idle`. All other bits read 0 except bit 1 (see R3).
- R3: A write to 0x10 with bit 1 set starts a soft reset lasting SRST_CYCLES (default 8) clock cycles after the write edge. During that time bit 1 of 0x10 reads 1 and bit 0 of the status word at 0x14 reads 0. Afterwards 0x10 bit 1 reads 0 and 0x14 bit 0 reads 1. After the hardware reset, 0x14 bit 0 reads 1.
- R4: A soft reset returns every register to its reset value of 0 (configuration, control, table base, interrupt status, interrupt mask, fault address). Bus writes and fault strobes presented while it runs, or in the cycle that starts it, have no effect.
- R5: Control word at 0x44: bit 1 enables translation (`xlate_en`), bit 2 enables the hardware table walk (`walk_en`), bit 3 enables the emulation TLB (`emu_tlb_en`). Other bits read 0.
- R6: Table base at 0x4C: bits 31:14 are writable and bits 13:0 read 0, so the table is 16 KB aligned. The stored value drives `ttb_base`.
- R7: Interrupt status at 0x18 uses this layout: bit 0 TLB miss, bit 1 translation fault, bit 2 emulation miss, bit 3 table-walk fault, bit 4 multi-hit fault. Strobe `flt_strobe[i]` sets bit i at that clock edge. Bits 31:5 read 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A strobe in the same cycle as a clear of the same bit leaves the bit set.
- R9: Interrupt mask at 0x1C uses the R7 layout. Bits 4:0 are read/write. `irq` is high exactly when some status bit and its mask bit are both 1, and it follows the registers one cycle after the edge that changes them.
- R10: The fault address at 0x48 (read-only) captures `flt_dev_addr` on any strobe edge when no masked-in status bit is pending before that edge. Otherwise it keeps the address it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| flt_strobe | input | 5 | One strobe per fault source, R7 layout |
| flt_dev_addr | input | 32 | Device address of the fault |
| irq | output | 1 | Interrupt request |
| xlate_en | output | 1 | Translation enable |
| walk_en | output | 1 | Hardware table-walk enable |
| emu_tlb_en | output | 1 | Emulation TLB enable |
| ttb_base | output | 32 | Translation table base address |
| idle_mode | output | 2 | Idle mode field |
| auto_idle | output | 1 | Auto-idle enable |

## Verification
A corrupted status or mask bit shows on `irq` in the very next cycle. A status bit that is not sticky, or a clear that misses, also shows when 0x18 is next read. A fault-address register that recaptures while a fault is pending shows only at the next read of 0x48, so the bench reads it after every burst of strobes. A soft-reset counter that is off by one shows as a flip of 0x14 bit 0 one cycle early or late. A missed wipe shows on the configuration outputs as soon as the reset starts. The reference model is compared on every cycle, so each of these is reported in the cycle it first becomes visible.

// File: rtl/iommu_reg_pkg.sv
package iommu_reg_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_FLT = 5;
  localparam int TTB_LSB = 14;

  // Byte offsets decoded by software drivers.
  localparam logic [ADDR_W-1:0] OFF_REV    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_SYSSTA = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IMASK  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_FADDR  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_TTB    = 8'h4C;

  localparam logic [DATA_W-1:0] REV_WORD = 32'h0000_0011;

  // Configuration word field positions.
  localparam int CFG_AUTO_BIT = 0;
  localparam int CFG_SRST_BIT = 1;
  localparam int CFG_IDLE_LSB = 3;

  // Control word field positions.
  localparam int CTL_XLATE_BIT = 1;
  localparam int CTL_WALK_BIT  = 2;
  localparam int CTL_EMU_BIT   = 3;

  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NONE  = 2'd1,
    IDLE_SMART = 2'd2
  } idle_mode_e;

  // Sticky status update: clear first, events override the clear.
  function automatic logic [NUM_FLT-1:0] w1c_next(
    input logic [NUM_FLT-1:0] cur,
    input logic [NUM_FLT-1:0] clr,
    input logic [NUM_FLT-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_masked(
    input logic [NUM_FLT-1:0] stat,
    input logic [NUM_FLT-1:0] mask
  );
    return |(stat & mask);
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(
    input logic [1:0] idle,
    input logic       auto_en,
    input logic       busy
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[CFG_IDLE_LSB +: 2] = idle;
    w[CFG_SRST_BIT]      = busy;
    w[CFG_AUTO_BIT]      = auto_en;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ttb(
    input logic [DATA_W-TTB_LSB-1:0] hi
  );
    return {hi, {TTB_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/iommu_srst_seq.sv
module iommu_srst_seq #(
  parameter int SRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b1;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CNT_LOAD;
    end else if (last_tick) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_on_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/iommu_fault_unit.sv
module iommu_fault_unit
  import iommu_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wipe,
  input  logic               freeze,
  input  logic               mask_we,
  input  logic [NUM_FLT-1:0] mask_wdata,
  input  logic               clr_we,
  input  logic [NUM_FLT-1:0] clr_wdata,
  input  logic [NUM_FLT-1:0] strobe,
  input  logic [DATA_W-1:0]  dev_addr,
  output logic [NUM_FLT-1:0] status,
  output logic [NUM_FLT-1:0] mask,
  output logic [DATA_W-1:0]  fault_addr,
  output logic               irq
);
  logic               live;
  logic               pending;
  logic               capture;
  logic [NUM_FLT-1:0] clr_mask;
  logic [NUM_FLT-1:0] ev_mask;
  logic [NUM_FLT-1:0] status_nx;

  assign live      = !wipe && !freeze;
  assign pending   = any_masked(status, mask);
  assign clr_mask  = clr_we ? clr_wdata : '0;
  assign ev_mask   = live ? strobe : '0;
  assign capture   = live && (|strobe) && !pending;
  assign status_nx = w1c_next(status, clr_mask, ev_mask);

  // One sticky status flop per source.
  for (genvar i = 0; i < NUM_FLT; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[i] <= 1'b0;
      else if (wipe)   status[i] <= 1'b0;
      else if (live)   status[i] <= status_nx[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      fault_addr <= '0;
    end else if (wipe) begin
      mask       <= '0;
      fault_addr <= '0;
    end else if (live) begin
      if (mask_we) mask <= mask_wdata;
      if (capture) fault_addr <= dev_addr;
    end
  end

  assign irq = pending;

  assert_sticky_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

  assert_strobe_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> ((status & $past(strobe)) == $past(strobe)));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pending) |=> $stable(fault_addr));

  assert_addr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !pending && (|strobe)) |=> (fault_addr == $past(dev_addr)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

endmodule

// File: rtl/iommu_regfile.sv
module iommu_regfile
  import iommu_reg_pkg::*;
#(
  parameter int SRST_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_FLT-1:0] flt_strobe,
  input  logic [DATA_W-1:0]  flt_dev_addr,
  output logic               irq,
  output logic               xlate_en,
  output logic               walk_en,
  output logic               emu_tlb_en,
  output logic [DATA_W-1:0]  ttb_base,
  output logic [1:0]         idle_mode,
  output logic               auto_idle
);
  localparam int TTB_HI_W = DATA_W - TTB_LSB;

  logic [ADDR_W-1:0]   off;
  logic                srst_busy;
  logic                srst_done;
  logic                wr_ok;
  logic                srst_start;
  logic                wr_cfg, wr_ctl, wr_ttb, wr_clr, wr_msk;
  logic [2:0]          ctl_q;
  logic [TTB_HI_W-1:0] ttb_q;
  logic [NUM_FLT-1:0]  st_q, msk_q;
  logic [DATA_W-1:0]   fa_q;

  assign off        = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_ok      = bus_sel && bus_wr && !srst_busy;
  assign srst_start = wr_ok && (off == OFF_SYSCFG) && bus_wdata[CFG_SRST_BIT];
  assign wr_cfg     = wr_ok && (off == OFF_SYSCFG) && !bus_wdata[CFG_SRST_BIT];
  assign wr_ctl     = wr_ok && (off == OFF_CTRL);
  assign wr_ttb     = wr_ok && (off == OFF_TTB);
  assign wr_clr     = wr_ok && (off == OFF_ISTAT);
  assign wr_msk     = wr_ok && (off == OFF_IMASK);

  iommu_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy),
    .done  (srst_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_mode <= IDLE_FORCE;
      auto_idle <= 1'b0;
      ctl_q     <= '0;
      ttb_q     <= '0;
    end else if (srst_start) begin
      idle_mode <= IDLE_FORCE;
      auto_idle <= 1'b0;
      ctl_q     <= '0;
      ttb_q     <= '0;
    end else begin
      if (wr_cfg) begin
        idle_mode <= bus_wdata[CFG_IDLE_LSB +: 2];
        auto_idle <= bus_wdata[CFG_AUTO_BIT];
      end
      if (wr_ctl) ctl_q <= bus_wdata[CTL_EMU_BIT:CTL_XLATE_BIT];
      if (wr_ttb) ttb_q <= bus_wdata[DATA_W-1:TTB_LSB];
    end
  end

  iommu_fault_unit u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe       (srst_start),
    .freeze     (srst_busy),
    .mask_we    (wr_msk),
    .mask_wdata (bus_wdata[NUM_FLT-1:0]),
    .clr_we     (wr_clr),
    .clr_wdata  (bus_wdata[NUM_FLT-1:0]),
    .strobe     (flt_strobe),
    .dev_addr   (flt_dev_addr),
    .status     (st_q),
    .mask       (msk_q),
    .fault_addr (fa_q),
    .irq        (irq)
  );

  assign xlate_en   = ctl_q[0];
  assign walk_en    = ctl_q[1];
  assign emu_tlb_en = ctl_q[2];
  assign ttb_base   = pack_ttb(ttb_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (off)
        OFF_REV:    bus_rdata = REV_WORD;
        OFF_SYSCFG: bus_rdata = pack_cfg(idle_mode, auto_idle, srst_busy);
        OFF_SYSSTA: bus_rdata = {{(DATA_W-1){1'b0}}, srst_done};
        OFF_ISTAT:  bus_rdata = {{(DATA_W-NUM_FLT){1'b0}}, st_q};
        OFF_IMASK:  bus_rdata = {{(DATA_W-NUM_FLT){1'b0}}, msk_q};
        OFF_CTRL:   bus_rdata = {{(DATA_W-4){1'b0}}, ctl_q, 1'b0};
        OFF_FADDR:  bus_rdata = fa_q;
        OFF_TTB:    bus_rdata = ttb_base;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assert_quiet_in_srst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (!xlate_en && !walk_en && !emu_tlb_en && ttb_base == '0 && !irq));

  assert_ttb_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ttb_base[TTB_LSB-1:0] == '0);

endmodule

// File: tb/iommu_regfile_tb.sv
module iommu_regfile_tb;
  localparam int SRST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  flt_strobe = '0;
  logic [31:0] flt_dev_addr = '0;
  logic        irq, xlate_en, walk_en, emu_tlb_en, auto_idle;
  logic [31:0] ttb_base;
  logic [1:0]  idle_mode;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  int m_idle = 0, m_auto = 0, m_ctl = 0, m_st = 0, m_msk = 0, m_rem = 0, m_done = 1;
  longint unsigned m_ttb = 0, m_fa = 0;

  always #2.5 clk = ~clk;

  iommu_regfile #(.SRST_CYCLES(SRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flt_strobe(flt_strobe), .flt_dev_addr(flt_dev_addr), .irq(irq),
    .xlate_en(xlate_en), .walk_en(walk_en), .emu_tlb_en(emu_tlb_en),
    .ttb_base(ttb_base), .idle_mode(idle_mode), .auto_idle(auto_idle)
  );

  function automatic longint unsigned ref_read();
    int a;
    if (!bus_sel || bus_wr) return 0;
    a = int'(bus_addr) & 'hFC;
    case (a)
      'h00: return 'h11;
      'h10: return (m_idle * 8) + ((m_rem > 0) ? 2 : 0) + m_auto;
      'h14: return m_done;
      'h18: return m_st;
      'h1C: return m_msk;
      'h44: return m_ctl * 2;
      'h48: return m_fa;
      'h4C: return m_ttb;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a & 'hFC)
      'h10: return "R2/R3";
      'h14: return "R3";
      'h18: return "R7/R8";
      'h1C: return "R9";
      'h44: return "R5";
      'h48: return "R10";
      'h4C: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag_of(int'(bus_addr)), bus_rdata, ref_read());
    chk("R9 irq", irq, ((m_st & m_msk) != 0));
    chk("R5 xlate_en", xlate_en, m_ctl & 1);
    chk("R5 walk_en", walk_en, (m_ctl >> 1) & 1);
    chk("R5 emu_tlb_en", emu_tlb_en, (m_ctl >> 2) & 1);
    chk("R6 ttb_base", ttb_base, m_ttb);
    chk("R2 idle_mode", idle_mode, m_idle);
    chk("R2 auto_idle", auto_idle, m_auto);
  endtask

  // Behavioural model of one clock edge, using the inputs held over it.
  task automatic model_edge();
    int a, wd, clr, ev;
    bit wr_ok, pend;
    a  = int'(bus_addr) & 'hFC;
    wd = int'(bus_wdata);
    if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) m_done = 1;
      return;
    end
    wr_ok = bus_sel && bus_wr;
    if (wr_ok && a == 'h10 && ((wd >> 1) & 1)) begin
      m_idle = 0; m_auto = 0; m_ctl = 0; m_ttb = 0;
      m_st = 0; m_msk = 0; m_fa = 0; m_rem = SRST; m_done = 0;
      return;
    end
    pend = (m_st & m_msk) != 0;
    ev   = int'(flt_strobe);
    clr  = (wr_ok && a == 'h18) ? (wd & 'h1F) : 0;
    if (ev != 0 && !pend) m_fa = flt_dev_addr;
    m_st = (m_st & ~clr) | ev;
    if (wr_ok) begin
      case (a)
        'h10: begin m_idle = (wd >> 3) & 3; m_auto = wd & 1; end
        'h1C: m_msk = wd & 'h1F;
        'h44: m_ctl = (wd >> 1) & 7;
        'h4C: m_ttb = longint'(bus_wdata) & 64'hFFFF_C000;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(bit sel, bit wr, int addr, longint unsigned wd, int fv, longint unsigned fa);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = 8'(addr); bus_wdata = 32'(wd);
    flt_strobe = 5'(fv); flt_dev_addr = 32'(fa);
    #1;
    compare_all();
    @(posedge clk);
    if (rst_n) model_edge();
  endtask

  task automatic rd(int a);                cyc(1, 0, a, 0, 0, 0);  endtask
  task automatic wr(int a, longint unsigned d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic flt(int v, longint unsigned fa); cyc(0, 0, 0, 0, v, fa); endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state (R1, R3)
    repeat (2) cyc(0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    rd('h14); rd('h00); rd('h10); rd('h18); rd('h48);
    // unimplemented offsets and low address bits ignored (R1)
    rd('h04); rd('h20); rd('h40); rd('hFC); rd('h03); rd('h4E);
    cyc(1, 1, 'h00, 'hFFFF_FFFF, 0, 0); rd('h00);
    // configuration (R2)
    wr('h10, 'h11); rd('h10);
    wr('h10, 'hFFFF_FFE5); rd('h10);
    wr('h10, 'h09); rd('h10);
    // control (R5), table base (R6)
    wr('h44, 'hFFFF_FFFF); rd('h44);
    wr('h44, 'h0000_0004); rd('h44);
    wr('h4C, 'hFFFF_FFFF); rd('h4C);
    wr('h4C, 'h1234_5678); rd('h4C);
    // faults, mask, capture (R7, R9, R10)
    flt('h02, 'hAAAA_0000); rd('h18); rd('h48);
    wr('h1C, 'h1F); rd('h1C);
    flt('h08, 'hBBBB_0000); rd('h18); rd('h48);
    // write-one-to-clear (R8)
    wr('h18, 'h0); rd('h18);
    wr('h18, 'h02); rd('h18);
    wr('h18, 'h08); rd('h18);
    flt('h10, 'hCCCC_0000); rd('h48);
    // clear and strobe on the same bit (R8)
    cyc(1, 1, 'h18, 'h10, 'h10, 'hDDDD_0000); rd('h18); rd('h48);
    wr('h18, 'h1F);
    // mask closed: each strobe recaptures (R10)
    wr('h1C, 'h0);
    flt('h01, 'h1111_1000); rd('h48);
    flt('h04, 'h2222_2000); rd('h48); rd('h18);
    wr('h1C, 'h01); rd('h1C);
    wr('h18, 'h1F);
    // soft reset (R3, R4)
    wr('h10, 'h13); wr('h44, 'hE); wr('h4C, 'hFFFF_C000); flt('h1F, 'h5555_0000);
    wr('h10, 'h02);
    for (int i = 0; i < SRST + 2; i++) begin
      case (i % 4)
        0: cyc(1, 1, 'h44, 'hE, 'h1F, 'h7777_0000);
        1: rd('h14);
        2: rd('h10);
        default: wr('h10, 'h02);
      endcase
    end
    rd('h14); rd('h18); rd('h1C); rd('h48); rd('h4C); rd('h44);
    // start cycle with a simultaneous strobe (R4)
    cyc(1, 1, 'h10, 'h02, 'h1F, 'h9999_0000);
    repeat (SRST) rd('h14);
    rd('h18); rd('h48);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: rd('h18);
        1: rd('h48);
        2: wr('h18, $urandom);
        3: wr('h1C, $urandom);
        4: flt($urandom_range(0, 31), $urandom);
        5: cyc(1, 1, 'h18, $urandom, $urandom_range(0, 31), $urandom);
        6: wr('h44, $urandom);
        7: wr('h4C, $urandom);
        8: wr('h10, $urandom & 'hFFFF_FFFD);
        default: cyc(1, 0, $urandom_range(0, 255), 0, $urandom_range(0, 31), $urandom);
      endcase
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule